// File: doc/BRIEF.md
# Dual-Format Asynchronous Frame Transmitter

This block turns one data byte into an asynchronous serial frame on a single output line. It supports two frame layouts. The short layout has 10 bits. The long layout has 11 bits and adds an extra bit, supplied by software, between the last data bit and the stop bit. A single write strobe captures the byte, the extra-bit value and the layout choice.

The block does not generate its own baud rate. A shared divide-by-16 baud counter outside the block supplies a rollover pulse, one per bit period. Every bit edge on the line, the start bit included, comes a fixed number of system clocks after a rollover. A frame therefore begins at the first rollover that follows the write, plus that fixed latency. When the stop bit goes onto the line, a done flag rises. The flag stays set until software clears it.

Top module: `ser_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `tx_line` is 1. After reset, `tx_done` is 0.
- R2: With `wr_wide`=0 at the write, the frame has 10 bits: one start bit of 0, then `wr_data` bit 0 through bit 7, then one stop bit of 1.
- R3: With `wr_wide`=1 at the write, the frame has 11 bits: start 0, `wr_data` bit 0 through bit 7, then the `wr_ninth` value, then stop 1.
- R4: `wr_data`, `wr_ninth` and `wr_wide` are sampled only in the clock cycle in which `wr_stb` is high. Changing them later does not alter the frame.
- R5: The line falls to the start bit at the clock edge that comes START_LAT (default 5) edges after the first edge that samples `baud_roll` high strictly after the edge that sampled `wr_stb`.
- R6: Each bit, start and stop included, stays on the line for one rollover period. The next bit appears START_LAT edges after the following rollover.
- R7: `tx_done` rises at the same clock edge at which the stop bit is placed on the line, and not before.
- R8: `tx_done` stays 1 until `tx_done_clr` is sampled high. If a set and a clear coincide, the set wins.
- R9: A `wr_stb` that arrives while a frame is pending or being sent has no effect. No extra frame is sent, and the running frame is not changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_roll | input | 1 | One-cycle pulse at each 16-tick boundary of the shared baud counter |
| wr_stb | input | 1 | Write strobe that loads the byte and starts a frame |
| wr_data | input | DATA_W | Byte to send, least significant bit first |
| wr_ninth | input | 1 | Extra bit value, used in the 11-bit layout only |
| wr_wide | input | 1 | Layout select: 0 = 10-bit frame, 1 = 11-bit frame |
| tx_done_clr | input | 1 | Software clear for the done flag |
| tx_line | output | 1 | Serial output line |
| tx_done | output | 1 | Transmit-complete flag |

## Verification
On every cycle, the assertions check the following:
- the line is high while the block is idle;
- the line changes only on a post-rollover step;
- the first step after arming drives a low start bit;
- a strobe during a frame leaves the captured byte untouched;
- the done flag only rises while the line carries a 1.

Only the bench scenarios can show the rest:
- the exact bit order of both layouts;
- the five-clock start alignment, measured against writes placed just before a rollover and exactly on one;
- that a late change to the write inputs is ignored;
- that the done flag rises exactly at the stop bit, holds until cleared, and wins over a clear in the same cycle.

// File: rtl/sft_pkg.sv
// Shared types for the serial frame transmitter.
package sft_pkg;
    // Sequencer states: idle, waiting for a rollover, waiting for the post-rollover step, shifting bits.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_PEND  = 2'd2,
        ST_SHIFT = 2'd3
    } sft_state_e;
endpackage

// File: rtl/sft_align.sv
// Bit-step generator.
// What it does: produces a one-cycle step pulse START_LAT clocks after each
// rollover of the shared divide-by-16 baud counter. Each rollover reloads the delay.
// Assumes: START_LAT >= 1, and rollovers are more than START_LAT clocks apart.
module sft_align #(
    parameter int START_LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_roll,
    output logic step
);
    localparam int CW = $clog2(START_LAT + 1);

    logic [CW-1:0] dly_cnt;

    // Delay counter: reload on rollover, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_cnt <= '0;
        end else if (baud_roll) begin
            dly_cnt <= CW'(START_LAT);
        end else if (dly_cnt != '0) begin
            dly_cnt <= dly_cnt - 1'b1;
        end
    end

    // The step fires in the last cycle of the countdown.
    assign step = (dly_cnt == CW'(1));

    // R6: a step needs a rollover within the last START_LAT cycles, so two steps are never adjacent.
    a_r6_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);
endmodule

// File: rtl/sft_framer.sv
// Frame sequencer and shifter.
// What it does: captures the byte, extra bit and layout on a write strobe. It waits
// for the next rollover, then for the step that follows it, and then drives the
// frame one bit per step. It pulses stop_set when the stop bit is driven.
// Assumes: step comes from sft_align, fed by the same baud_roll.
module sft_framer
    import sft_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_ninth,
    input  logic              wr_wide,
    input  logic              baud_roll,
    input  logic              step,
    output logic              tx_line,
    output logic              stop_set
);
    localparam int FW = DATA_W + 3;
    localparam int IW = $clog2(FW);

    sft_state_e        state;
    logic [DATA_W-1:0] data_q;
    logic              ninth_q;
    logic              wide_q;
    logic [IW-1:0]     idx;
    logic [IW-1:0]     nxt_idx;
    logic [IW-1:0]     last_idx;
    logic [FW-1:0]     frame;
    logic              tx_q;

    // Frame image: bit 0 is the start bit. In the short layout, slot DATA_W+1 is the stop bit.
    always_comb begin
        frame    = {1'b1, (wide_q ? ninth_q : 1'b1), data_q, 1'b0};
        last_idx = wide_q ? IW'(FW - 1) : IW'(FW - 2);
        nxt_idx  = idx + 1'b1;
    end

    // The done flag is raised when the step places the stop bit.
    assign stop_set = (state == ST_SHIFT) && step && (nxt_idx == last_idx);
    assign tx_line  = tx_q;

    // Sequencer, capture registers and line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            data_q  <= '0;
            ninth_q <= 1'b0;
            wide_q  <= 1'b0;
            idx     <= '0;
            tx_q    <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (wr_stb) begin
                        data_q  <= wr_data;
                        ninth_q <= wr_ninth;
                        wide_q  <= wr_wide;
                        state   <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (baud_roll) state <= ST_PEND;
                end
                ST_PEND: begin
                    if (step) begin
                        idx   <= '0;
                        tx_q  <= frame[0];
                        state <= ST_SHIFT;
                    end
                end
                default: begin
                    if (step) begin
                        if (idx == last_idx) begin
                            tx_q  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            idx  <= nxt_idx;
                            tx_q <= frame[nxt_idx];
                        end
                    end
                end
            endcase
        end
    end

    // R1: the line is high whenever the sequencer is idle.
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> tx_q);

    // R6: the line only moves on a step.
    a_r6_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(tx_q));

    // R5: the first step after arming drives the start bit low.
    a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND && step) |=> !tx_q);

    // R9: a strobe during a frame leaves the captured byte untouched.
    a_r9_ignore_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && wr_stb) |=> $stable(data_q));
endmodule

// File: rtl/sft_flag.sv
// Transmit-complete flag.
// What it does: sets on the stop-bit pulse and clears on the software clear.
// A set wins over a clear in the same cycle.
// Assumes: stop_set is a single-cycle pulse.
module sft_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_set,
    input  logic clr,
    output logic flag
);
    // Flag register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (stop_set) flag <= 1'b1;
        else if (clr)      flag <= 1'b0;
    end

    // R8: with no set and no clear, the flag keeps its value.
    a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_set && !clr) |=> $stable(flag));
endmodule

// File: rtl/ser_frame_tx.sv
// Dual-format asynchronous frame transmitter (top).
// What it does: ties the step generator, the frame sequencer and the done flag together.
// Assumes: baud_roll comes from a shared divide-by-16 baud counter, one pulse per bit period.
module ser_frame_tx #(
    parameter int DATA_W    = 8,
    parameter int START_LAT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_roll,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_ninth,
    input  logic              wr_wide,
    input  logic              tx_done_clr,
    output logic              tx_line,
    output logic              tx_done
);
    logic step;
    logic stop_set;

    sft_align #(.START_LAT(START_LAT)) align_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_roll (baud_roll),
        .step      (step)
    );

    sft_framer #(.DATA_W(DATA_W)) framer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .wr_ninth  (wr_ninth),
        .wr_wide   (wr_wide),
        .baud_roll (baud_roll),
        .step      (step),
        .tx_line   (tx_line),
        .stop_set  (stop_set)
    );

    sft_flag flag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_set (stop_set),
        .clr      (tx_done_clr),
        .flag     (tx_done)
    );

    // R7: the done flag only rises while the line carries a 1 (the stop bit).
    a_r7_done_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> tx_line);
endmodule

// File: tb/ser_frame_tx_tb_top.sv
// Scoreboard bench: the driver queues the expected frames, and the monitor checks them off the line.
module ser_frame_tx_tb_top;
    localparam int P   = 20;   // clocks per rollover period
    localparam int LAT = 5;

    logic       clk = 1'b0, rst_n = 1'b0, roll = 1'b0, wr_stb = 1'b0;
    logic       ninth = 1'b0, wide = 1'b0, clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx, ti;

    ser_frame_tx #(.DATA_W(8), .START_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .baud_roll(roll), .wr_stb(wr_stb),
        .wr_data(wr_data), .wr_ninth(ninth), .wr_wide(wide),
        .tx_done_clr(clr), .tx_line(tx), .tx_done(ti)
    );

    always #5 clk = ~clk;

    int edge_no = 0;
    always @(posedge clk) edge_no <= edge_no + 1;

    // Rollover is sampled high on posedges whose number is a multiple of P.
    always @(negedge clk) roll = ((edge_no + 1) % P == 0);

    typedef struct {
        logic [10:0] bits;
        int          nb;
        int          start_edge;
        string       tag;
    } exp_t;
    exp_t q[$];

    int checks = 0, errors = 0, sent = 0, seen = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a negedge: drive one strobe and queue the expected frame.
    task automatic strobe_now(input logic [7:0] d, input logic n, input logic w,
                              input string tag, output int stop_edge);
        exp_t e;
        int   wedge;
        wr_stb  = 1'b1; wr_data = d; ninth = n; wide = w;
        wedge   = edge_no + 1;
        e.start_edge = ((wedge / P) + 1) * P + LAT;
        e.bits       = 11'h7FF;
        e.bits[0]    = 1'b0;
        e.bits[8:1]  = d;
        if (w) begin e.bits[9] = n; e.nb = 11; end
        else   e.nb = 10;
        e.tag     = tag;
        stop_edge = e.start_edge + (e.nb - 1) * P;
        q.push_back(e);
        sent++;
        @(negedge clk);
        wr_stb = 1'b0; wr_data = ~d; ninth = ~n; wide = ~w;   // R4: late changes
    endtask

    task automatic send(input logic [7:0] d, input logic n, input logic w, input string tag);
        int s;
        @(negedge clk);
        strobe_now(d, n, w, tag, s);
    endtask

    task automatic send_at(input int res, input logic [7:0] d, input logic w, input string tag);
        int s;
        @(negedge clk);
        while ((edge_no + 1) % P != res) @(negedge clk);
        strobe_now(d, 1'b0, w, tag, s);
    endtask

    task automatic wait_frames();
        while (seen < sent) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    // Monitor: detect a start bit and check the frame against the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx === 1'b0) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected frame at edge", edge_no, -1);
                    while (tx !== 1'b1) @(negedge clk);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(edge_no == e.start_edge, "R5", "start bit edge", edge_no, e.start_edge);
                    for (int off = 0; off < e.nb * P; off++) begin
                        if (off > 0) @(negedge clk);
                        if (off % P == P / 2)
                            chk(tx == e.bits[off / P], e.tag, "bit value mid-period",
                                int'(tx), int'(e.bits[off / P]));
                        if (off % P == P - 1)
                            chk(tx == e.bits[off / P], "R6", "bit value end of period",
                                int'(tx), int'(e.bits[off / P]));
                        if (off == (e.nb - 1) * P - 1)
                            chk(ti == 1'b0, "R7", "done before stop", int'(ti), 0);
                        if (off == (e.nb - 1) * P)
                            chk(ti == 1'b1 && tx == 1'b1, "R7", "done at stop", int'(ti), 1);
                    end
                    seen++;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", seen, sent);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int stop_e;
        repeat (5) @(negedge clk);
        chk(tx == 1'b1, "R1", "line in reset", int'(tx), 1);
        chk(ti == 1'b0, "R1", "done in reset", int'(ti), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx == 1'b1 && ti == 1'b0, "R1", "idle after reset", int'(tx), 1);

        send(8'hA5, 1'b0, 1'b0, "R2");       wait_frames(); clear_flag();
        chk(tx == 1'b1, "R1", "idle between frames", int'(tx), 1);
        send(8'h3C, 1'b1, 1'b1, "R3");       wait_frames(); clear_flag();
        send(8'hC3, 1'b0, 1'b1, "R3");       wait_frames(); clear_flag();
        send(8'h00, 1'b1, 1'b0, "R2 R4");    wait_frames(); clear_flag();
        send(8'hFF, 1'b0, 1'b1, "R3 R4");    wait_frames(); clear_flag();

        // R5: write just before a rollover, and write on a rollover edge.
        send_at(P - 1, 8'h81, 1'b0, "R5");   wait_frames(); clear_flag();
        send_at(0,     8'h7E, 1'b1, "R5");   wait_frames(); clear_flag();

        // R9: strobes while pending and while shifting are ignored.
        send(8'h5A, 1'b0, 1'b0, "R9");
        @(negedge clk); wr_stb = 1'b1; wr_data = 8'h11; wide = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        repeat (3 * P) @(negedge clk);
        wr_stb = 1'b1; wr_data = 8'h22;
        @(negedge clk); wr_stb = 1'b0;
        wait_frames();
        repeat (4 * P) @(negedge clk);
        chk(tx == 1'b1, "R9", "no extra frame, line idle", int'(tx), 1);
        clear_flag();

        // R8: the flag holds until cleared.
        send(8'h96, 1'b1, 1'b1, "R3");       wait_frames();
        repeat (50) @(negedge clk);
        chk(ti == 1'b1, "R8", "done holds without clear", int'(ti), 1);
        clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk(ti == 1'b0, "R8", "done cleared", int'(ti), 0);

        // R8: a set in the same cycle as a clear wins.
        @(negedge clk);
        strobe_now(8'h42, 1'b0, 1'b0, "R2", stop_e);
        while (edge_no + 1 != stop_e) @(negedge clk);
        clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk(ti == 1'b1, "R8", "set wins over clear", int'(ti), 1);
        wait_frames(); clear_flag();

        chk(q.size() == 0, "R9", "scoreboard empty", q.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule